// File: doc/BRIEF.md
# Multi-Channel ADC Scan Sequencer

This block decides which input channel of a five-channel oversampling converter is being converted and when each conversion finishes. One trigger, from software or from a hardware event, starts a scan. The scan steps through the enabled channels from the lowest channel number upward. Each channel gets a burst of back-to-back conversions, and only when the burst is complete does the sequencer move to the next enabled channel.

The burst length comes from two per-channel coefficients through one of two formulas. A channel may also average several raw conversions into one result, and that averaged result counts as one conversion of the burst. The modulator and the decimation filter are not part of this block. Conversion timing is modelled by counting clock cycles: the block clock stands for the oversampling clock, and one raw conversion ends every oversampling-ratio cycles.

The block can run a single scan per trigger or scan continuously. It reports the active channel, a strobe at each raw conversion boundary, a pulse for each finished result, a pulse at the end of each scan, and a busy flag.

Top module: `adc_scan_seq`

## Requirements
- R1: Enabled channels are converted in ascending channel-number order. All conversions of one channel are performed back to back before the next enabled channel starts.
- R2: A raw conversion takes BASE_PERIOD << k clock cycles, where k is the channel's 3-bit ratio code. Codes 5, 6 and 7 all give BASE_PERIOD*32. With the default BASE_PERIOD of 64, the codes select ratios 64 to 2048.
- R3: The burst length N of a channel is set by its formula bit. With the bit at 0 (exponential), N = 32*(2^n - 1) + m*2^n. With the bit at 1 (linear), N = 32*n + m.
- R4: A channel whose coefficients n and m are both zero is invalid. It is skipped as if it were disabled.
- R5: The 3-bit averaging code gives the number of raw conversions per result: 1 gives 8, 2 gives 16, 3 gives 32, and 4 to 7 give 64. The conversion-end pulse fires once per averaged result, and each averaged result counts as one conversion toward N.
- R6: With averaging code 0, the conversion-end pulse fires together with every raw conversion strobe.
- R7: The scan-end pulse fires once, in the same cycle as the last conversion-end of the highest enabled channel.
- R8: With continuous mode at 0, a scan runs once and busy is low in the cycle after scan-end.
- R9: With continuous mode at 1, the scan restarts at the lowest enabled channel after each scan-end, and busy stays high.
- R10: A software start or a hardware trigger that arrives while busy is ignored.
- R11: A stop request ends the scan at the next conversion boundary. Busy then drops and no scan-end is raised. A stop request while idle has no effect.
- R12: A trigger with no valid enabled channel leaves the block idle.
- R13: After reset, busy is low and no strobes occur until a trigger arrives.
- R14: conv_ch gives the channel number of the conversion that is strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_en | input | NCH | Channel enable mask, bit i enables channel i |
| os_sel | input | 3*NCH | Ratio code per channel, channel i at bits [3i+2:3i] |
| avg_sel | input | 3*NCH | Averaging code per channel, channel i at bits [3i+2:3i] |
| form_lin | input | NCH | Formula bit per channel: 0 exponential, 1 linear |
| coef_n | input | NW*NCH | Coefficient n per channel |
| coef_m | input | MW*NCH | Coefficient m per channel |
| mode_cont | input | 1 | 1 selects continuous scanning |
| sw_start | input | 1 | Software start pulse |
| hw_trig | input | 1 | Hardware trigger pulse |
| stop | input | 1 | Stop request |
| busy | output | 1 | A scan is in progress |
| conv_ch | output | CHW | Channel being converted |
| conv_strobe | output | 1 | Raw conversion boundary |
| conv_end | output | 1 | Result finished (after averaging) |
| scan_end | output | 1 | All enabled channels finished |

## Verification
The bench builds the block with BASE_PERIOD = 2 and the other parameters at their defaults. With that setting, even the clamped ratio code gives 64 cycles per conversion. Bursts of more than a hundred conversions per channel, averaging depths up to 16, and full five-channel scans then finish in a few thousand cycles, so exact strobe, result and busy-cycle totals can be compared for each configuration. The short period also lets continuous scanning run through several wrap-arounds, and lets a stop land at a boundary within a few cycles.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  // Raw conversions per reported result for an averaging code.
  function automatic int unsigned avg_depth(input int unsigned code);
    case (code)
      0:       return 1;
      1:       return 8;
      2:       return 16;
      3:       return 32;
      default: return 64;
    endcase
  endfunction

  // Cycles per raw conversion, with ratio codes above 5 clamped to 5.
  function automatic int unsigned os_period(input int unsigned code, input int unsigned base);
    int unsigned k;
    k = (code > 5) ? 5 : code;
    return base << k;
  endfunction

  // Number of results in one channel burst.
  function automatic int unsigned burst_len(input logic lin, input int unsigned n,
                                            input int unsigned m);
    if (lin) return 32 * n + m;
    return 32 * ((1 << n) - 1) + (m << n);
  endfunction

endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [PW-1:0] period,
  output logic          tick
);
  logic [PW-1:0] cnt_q;

  assign tick = run && (cnt_q == period - PW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run || tick)   cnt_q <= '0;
    else                     cnt_q <= cnt_q + PW'(1);
  end

  // R2: the counter never runs past the period
  a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < period));
  // R2: every scan begins with a full period
  a_r2_fresh_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (cnt_q == '0));
endmodule

// File: rtl/adc_seq_pick.sv
module adc_seq_pick #(
  parameter int NCH = 5,
  parameter int CHW = 3
) (
  input  logic [NCH-1:0] mask,
  input  logic [CHW-1:0] cur,
  output logic           any,
  output logic [CHW-1:0] first,
  output logic           has_next,
  output logic [CHW-1:0] next
);
  always_comb begin
    any      = 1'b0;
    first    = '0;
    has_next = 1'b0;
    next     = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (mask[i]) begin
        any   = 1'b1;
        first = CHW'(i);
        if (CHW'(i) > cur) begin
          has_next = 1'b1;
          next     = CHW'(i);
        end
      end
    end
  end
endmodule

// File: rtl/adc_seq_burst.sv
module adc_seq_burst #(
  parameter int LW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic [6:0]    depth,
  input  logic [LW-1:0] len,
  output logic          res_done,
  output logic          burst_done
);
  logic [6:0]    raw_q;
  logic [LW-1:0] res_q;
  logic          raw_last, res_last;

  assign raw_last   = (raw_q == depth - 7'd1);
  assign res_last   = (res_q == len - LW'(1));
  assign res_done   = tick && raw_last;
  assign burst_done = res_done && res_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
      res_q <= '0;
    end else if (clr) begin
      raw_q <= '0;
      res_q <= '0;
    end else if (tick) begin
      raw_q <= raw_last ? 7'd0 : raw_q + 7'd1;
      if (res_done) res_q <= res_last ? '0 : res_q + LW'(1);
    end
  end

  // R5: a finished result restarts the raw sample count
  a_r5_raw_restart: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |=> (raw_q == '0));
  // R6: without averaging every strobe yields a result
  a_r6_every_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && depth == 7'd1) |-> res_done);
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int NCH         = 5,
  parameter int NW          = 3,
  parameter int MW          = 5,
  parameter int BASE_PERIOD = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NCH-1:0]             ch_en,
  input  logic [3*NCH-1:0]           os_sel,
  input  logic [3*NCH-1:0]           avg_sel,
  input  logic [NCH-1:0]             form_lin,
  input  logic [NW*NCH-1:0]          coef_n,
  input  logic [MW*NCH-1:0]          coef_m,
  input  logic                       mode_cont,
  input  logic                       sw_start,
  input  logic                       hw_trig,
  input  logic                       stop,
  output logic                       busy,
  output logic [$clog2(NCH)-1:0]     conv_ch,
  output logic                       conv_strobe,
  output logic                       conv_end,
  output logic                       scan_end
);
  import adc_seq_pkg::*;

  localparam int CHW = $clog2(NCH);
  localparam int PW  = $clog2(BASE_PERIOD * 32) + 1;
  localparam int LW  = ((MW > 5) ? MW : 5) + (1 << NW) + 1;

  logic [NCH-1:0] eff_mask;
  logic [CHW-1:0] cur_ch, first_ch, next_ch;
  logic           any_ch, has_next;
  logic           busy_q, stop_pend;
  logic           tick, res_done, burst_done;
  logic           stop_hit, last_ch, trig;
  logic [2:0]     os_c, avg_c;
  logic           lin_c;
  logic [NW-1:0]  n_c;
  logic [MW-1:0]  m_c;
  logic [PW-1:0]  period;
  logic [6:0]     depth;
  logic [LW-1:0]  len;

  // A channel with both coefficients zero counts as disabled
  for (genvar i = 0; i < NCH; i++) begin : g_valid
    assign eff_mask[i] = ch_en[i] && ((coef_n[i*NW +: NW] != '0) || (coef_m[i*MW +: MW] != '0));
  end

  assign os_c   = os_sel[int'(cur_ch)*3 +: 3];
  assign avg_c  = avg_sel[int'(cur_ch)*3 +: 3];
  assign lin_c  = form_lin[cur_ch];
  assign n_c    = coef_n[int'(cur_ch)*NW +: NW];
  assign m_c    = coef_m[int'(cur_ch)*MW +: MW];
  assign period = PW'(os_period(os_c, BASE_PERIOD));
  assign depth  = 7'(avg_depth(avg_c));
  assign len    = LW'(burst_len(lin_c, n_c, m_c));

  adc_seq_pick #(.NCH(NCH), .CHW(CHW)) u_pick (
    .mask(eff_mask), .cur(cur_ch), .any(any_ch), .first(first_ch),
    .has_next(has_next), .next(next_ch));

  adc_seq_timer #(.PW(PW)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(busy_q), .period(period), .tick(tick));

  adc_seq_burst #(.LW(LW)) u_burst (
    .clk(clk), .rst_n(rst_n), .clr(!busy_q), .tick(tick), .depth(depth),
    .len(len), .res_done(res_done), .burst_done(burst_done));

  assign trig     = sw_start || hw_trig;
  assign stop_hit = tick && (stop_pend || stop);
  assign last_ch  = !has_next;

  assign busy        = busy_q;
  assign conv_ch     = cur_ch;
  assign conv_strobe = tick;
  assign conv_end    = res_done;
  assign scan_end    = burst_done && last_ch && !stop_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      cur_ch    <= '0;
      stop_pend <= 1'b0;
    end else if (!busy_q) begin
      stop_pend <= 1'b0;
      if (trig && any_ch) begin
        busy_q <= 1'b1;
        cur_ch <= first_ch;
      end
    end else begin
      if (stop) stop_pend <= 1'b1;
      if (stop_hit) begin
        busy_q    <= 1'b0;
        stop_pend <= 1'b0;
      end else if (burst_done) begin
        if (!last_ch)       cur_ch <= next_ch;
        else if (mode_cont) cur_ch <= first_ch;
        else                busy_q <= 1'b0;
      end
    end
  end

  // R1: moving on within a scan always goes to a higher channel
  a_r1_ascend: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_done && has_next && !stop_hit) |=> (cur_ch > $past(cur_ch)));
  // R7: scan end coincides with a finished result
  a_r7_with_result: assert property (@(posedge clk) disable iff (!rst_n)
    scan_end |-> conv_end);
  // R8: single mode goes idle after scan end
  a_r8_single_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_end && !mode_cont) |=> !busy);
  // R9: continuous mode stays busy across scan end
  a_r9_cont_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_end && mode_cont) |=> busy);
  // R11: busy only ever drops at a conversion boundary
  a_r11_drop_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(conv_strobe));
  // R12: with no valid channel the block cannot leave idle
  a_r12_stay_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && eff_mask == '0) |=> !busy);
  // R13: no strobe while idle
  a_r13_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !conv_strobe);
endmodule

// File: tb/test_adc_scan_seq.sv
module test_adc_scan_seq;
  localparam int NCH = 5;
  localparam int NW  = 3;
  localparam int MW  = 5;
  localparam int BP  = 2;

  typedef struct packed {
    logic [4:0]  mask;
    logic        lin;
    logic [2:0]  n;
    logic [4:0]  m;
    logic [2:0]  avg;
    logic [2:0]  os;
    logic [15:0] strobes;
    logic [15:0] convs;
    logic [1:0]  scans;
    logic [7:0]  per;
    logic [2:0]  first;
    logic [2:0]  last;
  } vec_t;

  // mask lin n m avg os | strobes convs scans period first last
  localparam vec_t TBL [6] = '{
    '{5'b00101, 1'b0, 3'd0, 5'd1, 3'd0, 3'd0, 16'd2,    16'd2,   2'd1, 8'd2,  3'd0, 3'd2},
    '{5'b10010, 1'b1, 3'd0, 5'd3, 3'd1, 3'd1, 16'd48,   16'd6,   2'd1, 8'd4,  3'd1, 3'd4},
    '{5'b11111, 1'b0, 3'd1, 5'd1, 3'd0, 3'd0, 16'd170,  16'd170, 2'd1, 8'd2,  3'd0, 3'd4},
    '{5'b01000, 1'b1, 3'd2, 5'd0, 3'd2, 3'd2, 16'd1024, 16'd64,  2'd1, 8'd8,  3'd3, 3'd3},
    '{5'b00001, 1'b0, 3'd0, 5'd0, 3'd0, 3'd0, 16'd0,    16'd0,   2'd0, 8'd2,  3'd0, 3'd0},
    '{5'b00110, 1'b0, 3'd2, 5'd3, 3'd0, 3'd7, 16'd216,  16'd216, 2'd1, 8'd64, 3'd1, 3'd2}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] ch_en = '0;
  logic [3*NCH-1:0] os_sel = '0, avg_sel = '0;
  logic [NCH-1:0] form_lin = '0;
  logic [NW*NCH-1:0] coef_n = '0;
  logic [MW*NCH-1:0] coef_m = '0;
  logic mode_cont = 1'b0, sw_start = 1'b0, hw_trig = 1'b0, stop = 1'b0;
  logic busy, conv_strobe, conv_end, scan_end;
  logic [2:0] conv_ch;

  always #5 clk = ~clk;

  adc_scan_seq #(.NCH(NCH), .NW(NW), .MW(MW), .BASE_PERIOD(BP)) i_adc_scan_seq (
    .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .os_sel(os_sel), .avg_sel(avg_sel),
    .form_lin(form_lin), .coef_n(coef_n), .coef_m(coef_m), .mode_cont(mode_cont),
    .sw_start(sw_start), .hw_trig(hw_trig), .stop(stop), .busy(busy),
    .conv_ch(conv_ch), .conv_strobe(conv_strobe), .conv_end(conv_end), .scan_end(scan_end));

  int n_chk = 0, n_err = 0;
  logic mon_clr = 1'b0;
  int exp_per = 2;
  int n_str, n_conv, n_scan, n_busy, bad_iv, bad_ord, first_seen, last_seen;
  int cyc = 0, prev_cyc, prev_ch;

  always @(negedge clk) begin
    cyc++;
    if (mon_clr) begin
      n_str = 0; n_conv = 0; n_scan = 0; n_busy = 0; bad_iv = 0; bad_ord = 0;
      first_seen = -1; last_seen = -1; prev_cyc = -1; prev_ch = 0;
    end else begin
      if (busy) n_busy++;
      if (conv_strobe) begin
        n_str++;
        if (prev_cyc >= 0 && (cyc - prev_cyc) != exp_per) bad_iv++;
        prev_cyc = cyc;
        if (int'(conv_ch) < prev_ch) bad_ord++;
        prev_ch = int'(conv_ch);
        if (first_seen < 0) first_seen = int'(conv_ch);
        last_seen = int'(conv_ch);
      end
      if (conv_end) n_conv++;
      if (scan_end) begin
        n_scan++;
        prev_ch = 0;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic mon_reset();
    mon_clr = 1'b1; step(); mon_clr = 1'b0;
  endtask

  task automatic apply(input vec_t v);
    ch_en    = v.mask;
    form_lin = {NCH{v.lin}};
    coef_n   = {NCH{v.n}};
    coef_m   = {NCH{v.m}};
    avg_sel  = {NCH{v.avg}};
    os_sel   = {NCH{v.os}};
    exp_per  = int'(v.per);
  endtask

  task automatic pulse_start(input logic use_hw);
    if (use_hw) hw_trig = 1'b1; else sw_start = 1'b1;
    step();
    hw_trig = 1'b0; sw_start = 1'b0;
  endtask

  task automatic wait_idle();
    int k = 0;
    while (busy && k < 60000) begin step(); k++; end
    repeat (3) step();
  endtask

  initial begin
    int guard;
    repeat (3) step();
    rst_n = 1'b1;
    mon_reset();
    repeat (10) step();
    // R13: idle after reset, nothing strobed
    check("R13 busy after reset", busy, 0);
    check("R13 strobes before trigger", n_str, 0);

    // table walk, single-scan mode
    foreach (TBL[i]) begin
      apply(TBL[i]);
      mode_cont = 1'b0;
      mon_reset();
      pulse_start(1'b0);
      if (TBL[i].scans == 0) repeat (20) step();
      wait_idle();
      check("R3 R4 R12 strobes per scan", n_str, int'(TBL[i].strobes));
      check("R5 R6 results per scan", n_conv, int'(TBL[i].convs));
      check("R7 scan-end count", n_scan, int'(TBL[i].scans));
      check("R2 busy cycles", n_busy, int'(TBL[i].strobes) * int'(TBL[i].per));
      check("R2 strobe spacing", bad_iv, 0);
      check("R1 ascending order", bad_ord, 0);
      check("R8 idle after single scan", busy, 0);
      if (TBL[i].scans != 0) begin
        check("R14 first channel", first_seen, int'(TBL[i].first));
        check("R1 last channel", last_seen, int'(TBL[i].last));
      end
    end

    // R4: invalid channel 0 skipped, valid channel 1 runs (linear m=2)
    ch_en = 5'b00011; form_lin = 5'b00010; coef_n = '0;
    coef_m = '0; coef_m[MW +: MW] = 5'd2; avg_sel = '0; os_sel = '0; exp_per = 2;
    mon_reset(); pulse_start(1'b0); wait_idle();
    check("R4 skip invalid channel strobes", n_str, 2);
    check("R4 first valid channel", first_seen, 1);

    // R10: hardware trigger starts; re-triggers while busy are ignored
    apply(TBL[1]); mon_reset();
    pulse_start(1'b1);
    repeat (30) step();
    pulse_start(1'b1);
    repeat (30) step();
    pulse_start(1'b0);
    wait_idle();
    check("R10 retrigger ignored scans", n_scan, 1);
    check("R10 retrigger ignored strobes", n_str, 48);

    // R11: stop while idle has no effect
    apply(TBL[0]); stop = 1'b1; step(); stop = 1'b0;
    mon_reset(); pulse_start(1'b0); wait_idle();
    check("R11 idle stop ignored", n_scan, 1);
    check("R11 idle stop strobes", n_str, 2);

    // R9: continuous mode wraps; R11: stop aborts without scan end
    apply(TBL[0]); mode_cont = 1'b1; mon_reset();
    pulse_start(1'b0);
    guard = 0;
    while (n_scan < 3 && guard < 1000) begin step(); guard++; end
    check("R9 busy across scans", busy, 1);
    check("R9 order restarts each scan", bad_ord, 0);
    stop = 1'b1; step(); stop = 1'b0;
    guard = 0;
    while (busy && guard < 20) begin step(); guard++; end
    check("R11 stop latency bounded", int'(guard <= exp_per), 1);
    check("R11 busy after stop", busy, 0);
    repeat (10) step();
    check("R11 no scan end on stop", n_scan, 3);
    mode_cont = 1'b0;

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule